// File: doc/BRIEF.md
# Fused Immediate-Operation Execution Unit

This unit is the execute stage for the unofficial immediate-mode operations of an 8-bit accumulator processor. It holds the accumulator, the index register X and four status flags (negative, overflow, zero, carry). On a strobe it takes an opcode byte and an immediate operand. At the next clock edge it writes A, X and the flags, and it raises a one-cycle completion pulse. That pulse carries two qualifiers: whether the operand byte was consumed, and whether the opcode was outside the unit's repertoire.

Each implemented operation fuses a bitwise AND with a second step and uses its own flag rule. The unit also decodes a set of immediate no-ops and one reserved code, all of which leave the state alone. Other datapath stages write A, X and the flags through a state-load port. That port takes priority over an operation strobe in the same cycle.

Top module: `imm_xu`

## Requirements
- R1: While rst_n is low, A, X, all four flags, done, imm_used and unsup read 0.
- R2: When st_load is high, A takes st_a, X takes st_x, and the flags take st_p at the next edge, with st_p[3]=N, st_p[2]=V, st_p[1]=Z, st_p[0]=C. An op strobe in the same cycle is discarded, so done stays 0.
- R3: Opcodes 0x0B and 0x2B set A to A&imm. C and N take bit 7 of the new A, and Z is set when the new A is 0.
- R4: Opcode 0x4B forms t=A&imm. C takes t[0], A becomes t shifted right logically by one, N becomes 0, and Z is set when the new A is 0.
- R5: Opcode 0x6B forms t=A&imm. A becomes {old C, t[7:1]}, C takes new A[6], V takes A[6]^A[5], N takes A[7], and Z is set when A is 0.
- R6: Opcode 0xCB sets X to ((A&X)-imm) modulo 256, ignoring the carry input. C is 1 exactly when A&X >= imm. N takes X[7], and Z is set when X is 0.
- R7: Opcodes 0x80, 0x82, 0x89, 0xC2 and 0xE2 change no register or flag. They report imm_used=1 and unsup=0.
- R8: Opcode 0xAB changes no register or flag. It reports imm_used=1 and unsup=0.
- R9: Any other opcode changes no register or flag. It reports unsup=1 and imm_used=0.
- R10: done is 1 in exactly the cycle after each accepted strobe. done, imm_used and unsup are 0 in every other cycle.
- R11: V keeps its value across every accepted operation other than opcode 0x6B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 8 | Opcode byte |
| op_imm | input | 8 | Immediate operand |
| st_load | input | 1 | Write A, X and flags from the datapath |
| st_a | input | 8 | Value to load into A |
| st_x | input | 8 | Value to load into X |
| st_p | input | 4 | Flags to load: {N,V,Z,C} |
| acc_o | output | 8 | Accumulator |
| xr_o | output | 8 | X register |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| done_o | output | 1 | Completion pulse |
| imm_used_o | output | 1 | Operand byte consumed (qualifies done) |
| unsup_o | output | 1 | Opcode not supported (qualifies done) |

## Verification
A state load and an operation strobe can arrive in the same cycle. The bench drives both together with differing values. It then expects the loaded A, X and flags exactly, and no completion pulse. Every other operation is preceded by a load of chosen A, X and flags, including the carry-in and overflow bits. This makes the fused results and the untouched flags comparable against a model computed in the bench.

// File: rtl/imm_xu_pkg.sv
package imm_xu_pkg;

  typedef enum logic [2:0] {
    K_UNK  = 3'd0,
    K_ANC  = 3'd1,
    K_ASR  = 3'd2,
    K_ARR  = 3'd3,
    K_AXS  = 3'd4,
    K_SKIP = 3'd5,
    K_HOLD = 3'd6
  } kind_t;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  localparam logic [7:0] OPC_ANC_A = 8'h0B;
  localparam logic [7:0] OPC_ANC_B = 8'h2B;
  localparam logic [7:0] OPC_ASR   = 8'h4B;
  localparam logic [7:0] OPC_ARR   = 8'h6B;
  localparam logic [7:0] OPC_AXS   = 8'hCB;
  localparam logic [7:0] OPC_RSVD  = 8'hAB;
  localparam int         NUM_SKIP  = 5;
  localparam logic [NUM_SKIP*8-1:0] OPC_SKIP_LIST = {8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2};

endpackage

// File: rtl/imm_xu_decode.sv
module imm_xu_decode
  import imm_xu_pkg::*;
(
  input  logic [7:0] opcode,
  output kind_t      kind
);

  logic [NUM_SKIP-1:0] skip_hit;

  for (genvar g = 0; g < NUM_SKIP; g++) begin : g_skip
    assign skip_hit[g] = (opcode == OPC_SKIP_LIST[g*8 +: 8]);
  end

  always_comb begin
    kind = K_UNK;
    if (|skip_hit) begin
      kind = K_SKIP;
    end else begin
      case (opcode)
        OPC_ANC_A, OPC_ANC_B: kind = K_ANC;
        OPC_ASR:              kind = K_ASR;
        OPC_ARR:              kind = K_ARR;
        OPC_AXS:              kind = K_AXS;
        OPC_RSVD:             kind = K_HOLD;
        default:              kind = K_UNK;
      endcase
    end
  end

endmodule

// File: rtl/imm_xu_alu.sv
module imm_xu_alu
  import imm_xu_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_t        kind,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] imm,
  input  flags_t       f_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] x_out,
  output flags_t       f_out,
  output logic         used,
  output logic         unsup
);

  localparam int MSB = W - 1;
  localparam int B6  = W - 2;
  localparam int B5  = W - 3;

  logic [W-1:0] and_ai;
  logic [W-1:0] and_ax;
  logic [W:0]   diff;
  logic [W-1:0] rot;

  assign and_ai = a_in & imm;
  assign and_ax = a_in & x_in;
  assign diff   = {1'b0, and_ax} - {1'b0, imm};
  assign rot    = {f_in.c, and_ai[W-1:1]};

  always_comb begin
    a_out = a_in;
    x_out = x_in;
    f_out = f_in;
    used  = 1'b1;
    unsup = 1'b0;
    case (kind)
      K_ANC: begin
        a_out   = and_ai;
        f_out.c = and_ai[MSB];
        f_out.n = and_ai[MSB];
        f_out.z = (and_ai == '0);
      end
      K_ASR: begin
        a_out   = and_ai >> 1;
        f_out.c = and_ai[0];
        f_out.n = 1'b0;
        f_out.z = (and_ai[W-1:1] == '0);
      end
      K_ARR: begin
        a_out   = rot;
        f_out.c = rot[B6];
        f_out.v = rot[B6] ^ rot[B5];
        f_out.n = rot[MSB];
        f_out.z = (rot == '0);
      end
      K_AXS: begin
        x_out   = diff[W-1:0];
        f_out.c = ~diff[W];
        f_out.n = diff[MSB];
        f_out.z = (diff[W-1:0] == '0);
      end
      K_SKIP, K_HOLD: begin
        used = 1'b1;
      end
      default: begin
        used  = 1'b0;
        unsup = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/imm_xu.sv
module imm_xu
  import imm_xu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [7:0]   op_code,
  input  logic [W-1:0] op_imm,
  input  logic         st_load,
  input  logic [W-1:0] st_a,
  input  logic [W-1:0] st_x,
  input  logic [3:0]   st_p,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] xr_o,
  output logic         flag_n_o,
  output logic         flag_v_o,
  output logic         flag_z_o,
  output logic         flag_c_o,
  output logic         done_o,
  output logic         imm_used_o,
  output logic         unsup_o
);

  logic [W-1:0] acc_q, acc_d, xr_q, xr_d;
  flags_t       flg_q, flg_d;
  logic         done_q, done_d, used_q, used_d, unsup_q, unsup_d;

  kind_t        kind;
  logic [W-1:0] alu_a, alu_x;
  flags_t       alu_f;
  logic         alu_used, alu_unsup;
  logic         take;
  logic         reg_en;

  imm_xu_decode u_dec (
    .opcode (op_code),
    .kind   (kind)
  );

  imm_xu_alu #(.W(W)) u_alu (
    .kind  (kind),
    .a_in  (acc_q),
    .x_in  (xr_q),
    .imm   (op_imm),
    .f_in  (flg_q),
    .a_out (alu_a),
    .x_out (alu_x),
    .f_out (alu_f),
    .used  (alu_used),
    .unsup (alu_unsup)
  );

  assign take   = op_valid & ~st_load;
  assign reg_en = st_load | take;

  // next-state
  always_comb begin
    acc_d   = acc_q;
    xr_d    = xr_q;
    flg_d   = flg_q;
    done_d  = take;
    used_d  = take & alu_used;
    unsup_d = take & alu_unsup;
    if (st_load) begin
      acc_d = st_a;
      xr_d  = st_x;
      flg_d = flags_t'(st_p);
    end else if (take) begin
      acc_d = alu_a;
      xr_d  = alu_x;
      flg_d = alu_f;
    end
  end

  // architectural state, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      xr_q  <= '0;
      flg_q <= '0;
    end else if (reg_en) begin
      acc_q <= acc_d;
      xr_q  <= xr_d;
      flg_q <= flg_d;
    end
  end

  // status pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      used_q  <= 1'b0;
      unsup_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      used_q  <= used_d;
      unsup_q <= unsup_d;
    end
  end

  assign acc_o      = acc_q;
  assign xr_o       = xr_q;
  assign flag_n_o   = flg_q.n;
  assign flag_v_o   = flg_q.v;
  assign flag_z_o   = flg_q.z;
  assign flag_c_o   = flg_q.c;
  assign done_o     = done_q;
  assign imm_used_o = used_q;
  assign unsup_o    = unsup_q;

endmodule

// File: rtl/imm_xu_chk.sv
module imm_xu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [7:0]   op_code,
  input logic         st_load,
  input logic [W-1:0] acc_o,
  input logic [W-1:0] xr_o,
  input logic         flag_n_o,
  input logic         flag_v_o,
  input logic         done_o,
  input logic         imm_used_o,
  input logic         unsup_o
);

  logic accepted;
  logic is_skip;
  assign accepted = op_valid & ~st_load;
  assign is_skip  = (op_code == 8'h80) || (op_code == 8'h82) || (op_code == 8'h89) ||
                    (op_code == 8'hC2) || (op_code == 8'hE2);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> (!done_o && !imm_used_o && !unsup_o));

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_load && op_valid) |=> !done_o);

  // R4
  asr_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && op_code == 8'h4B) |=> !flag_n_o);

  // R7
  skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && is_skip) |=> ($stable(acc_o) && $stable(xr_o) && imm_used_o && !unsup_o));

  // R9
  unsup_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> (done_o && !imm_used_o));

  // R11
  v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && op_code != 8'h6B) |=> $stable(flag_v_o));

endmodule

bind imm_xu imm_xu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .st_load    (st_load),
  .acc_o      (acc_o),
  .xr_o       (xr_o),
  .flag_n_o   (flag_n_o),
  .flag_v_o   (flag_v_o),
  .done_o     (done_o),
  .imm_used_o (imm_used_o),
  .unsup_o    (unsup_o)
);

// File: tb/imm_xu_bench.sv
module imm_xu_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, st_load;
  logic [7:0] op_code, op_imm, st_a, st_x;
  logic [3:0] st_p;
  logic [7:0] acc_o, xr_o;
  logic       flag_n_o, flag_v_o, flag_z_o, flag_c_o, done_o, imm_used_o, unsup_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  imm_xu u_imm_xu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_imm(op_imm),
    .st_load(st_load), .st_a(st_a), .st_x(st_x), .st_p(st_p),
    .acc_o(acc_o), .xr_o(xr_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o),
    .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .done_o(done_o),
    .imm_used_o(imm_used_o), .unsup_o(unsup_o)
  );

  // returns {A, X, N, V, Z, C, used, unsup}
  function automatic logic [21:0] model(input logic [7:0] op, imm, a, x, input logic [3:0] p);
    logic n, v, z, c, used, uns;
    logic [7:0] t;
    int d;
    n = p[3]; v = p[2]; z = p[1]; c = p[0]; used = 1'b1; uns = 1'b0;
    case (op)
      8'h0B, 8'h2B: begin t = a & imm; a = t; c = t[7]; n = t[7]; z = (t == 0); end
      8'h4B: begin t = a & imm; c = t[0]; a = t / 2; n = 1'b0; z = (a == 0); end
      8'h6B: begin
        t = a & imm; a = {c, t[7:1]}; c = a[6]; v = a[6] ^ a[5]; n = a[7]; z = (a == 0);
      end
      8'hCB: begin
        t = a & x; c = (int'(t) >= int'(imm)); d = int'(t) - int'(imm) + 256;
        x = d[7:0]; n = x[7]; z = (x == 0);
      end
      8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2, 8'hAB: used = 1'b1;
      default: begin used = 1'b0; uns = 1'b1; end
    endcase
    return {a, x, n, v, z, c, used, uns};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h0B, 8'h2B: return "R3";
      8'h4B: return "R4";
      8'h6B: return "R5";
      8'hCB: return "R6";
      8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2: return "R7";
      8'hAB: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [21:0] observed();
    return {acc_o, xr_o, flag_n_o, flag_v_o, flag_z_o, flag_c_o, imm_used_o, unsup_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a, x, input logic [3:0] p);
    st_load = 1'b1; st_a = a; st_x = x; st_p = p;
    @(negedge clk);
    st_load = 1'b0;
  endtask

  task automatic run_op(input logic [7:0] op, imm, a, x, input logic [3:0] p);
    logic [21:0] exp;
    do_load(a, x, p);
    exp = model(op, imm, a, x, p);
    op_valid = 1'b1; op_code = op; op_imm = imm;
    @(negedge clk);
    op_valid = 1'b0;
    check(tag_of(op), {9'd0, done_o, observed()}, {9'd0, 1'b1, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; st_load = 1'b0;
    op_code = '0; op_imm = '0; st_a = '0; st_x = '0; st_p = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {10'd0, observed()}, 32'd0);
    check("R1", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: plain load, then load colliding with an op strobe
    do_load(8'hA5, 8'h3C, 4'b1011);
    check("R2", {10'd0, observed()}, {10'd0, 8'hA5, 8'h3C, 4'b1011, 2'b00});
    st_load = 1'b1; st_a = 8'h12; st_x = 8'hF0; st_p = 4'b0100;
    op_valid = 1'b1; op_code = 8'h0B; op_imm = 8'h00;
    @(negedge clk);
    st_load = 1'b0; op_valid = 1'b0;
    check("R2", {9'd0, done_o, observed()}, {9'd0, 1'b0, 8'h12, 8'hF0, 4'b0100, 2'b00});

    // R10: pulse lasts one cycle
    run_op(8'h80, 8'h11, 8'h01, 8'h02, 4'b0000);
    @(negedge clk);
    check("R10", {29'd0, done_o, imm_used_o, unsup_o}, 32'd0);

    // every opcode from one state (R7, R8, R9 and the rest)
    for (int op = 0; op < 256; op++)
      run_op(8'(op), 8'h9E, 8'hC3, 8'h5A, 4'b0101);

    // R3, R4, R5, R11: fused AND ops over operand sweeps, both carry and V inputs
    for (int ai = 0; ai < 256; ai += 17)
      for (int ii = 0; ii < 256; ii += 3)
        for (int c = 0; c < 2; c++) begin
          run_op(8'h0B, 8'(ii), 8'(ai), 8'h77, {2'b01, 1'b0, 1'(c)});
          run_op(8'h2B, 8'(ii), 8'(ai), 8'h77, {2'b00, 1'b1, 1'(c)});
          run_op(8'h4B, 8'(ii), 8'(ai), 8'h77, {2'b11, 1'b0, 1'(c)});
          run_op(8'h6B, 8'(ii), 8'(ai), 8'h77, {2'b01, 1'b1, 1'(c)});
        end

    // R6: subtract sweep, carry input ignored
    for (int ai = 0; ai < 256; ai += 17)
      for (int xi = 0; xi < 256; xi += 51)
        for (int ii = 0; ii < 256; ii += 3)
          run_op(8'hCB, 8'(ii), 8'(ai), 8'(xi), {3'b010, 1'(ii & 1)});

    // R6: boundaries equal / one above / zero
    run_op(8'hCB, 8'h40, 8'hC0, 8'h7F, 4'b0000);
    run_op(8'hCB, 8'h41, 8'hC0, 8'h7F, 4'b0001);
    run_op(8'hCB, 8'h00, 8'h00, 8'h00, 4'b0000);
    // R5: carry-in lands in bit 7
    run_op(8'h6B, 8'hFF, 8'h00, 8'h00, 4'b0001);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule